// File: doc/BRIEF.md
# I2C Register-Access Target

This block lets an external I2C master read and write a small register array held inside the block. It answers only to the fixed 7-bit bus address 1000100. SCL and SDA are sampled by a faster system clock. SDA is driven as open drain: the block asserts `sda_oe` to pull the line low and never drives it high. START, repeated START and STOP are recognised from the sampled lines. The first byte after the device address byte loads a register pointer. Each further byte of a write goes into the array. A read returns bytes from the pointer onward.

On the sensor side, `reg_rd_addr` / `reg_rd_data` read the same array combinationally. Each byte that the bus commits is also reported as a one-cycle `wr_strobe` with its address and value. The pointer advances after each byte and wraps at the end of the array. A write that is cut short by STOP before its data byte and acknowledge finish changes nothing. After a write that ends in STOP, and after reset, the block ignores the bus for a programmable number of cycles.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset `sda_oe` and `wr_strobe` are 0 and every register reads 0. A START that arrives within PWRUP_CYCLES cycles of reset release is ignored, so the address byte after it gets no ACK.
- R2: Only address bytes whose upper seven bits are 1000100 are acknowledged: 0x88 selects a write and 0x89 a read. For any other address byte the block sends no ACK, never pulls SDA low, and changes no register until the next START.
- R3: In a write (0x88, register byte, data byte), all three bytes are acknowledged. The data lands in the addressed register. A single-cycle `wr_strobe` reports that register on `wr_addr` and the byte on `wr_data`.
- R4: In a burst write, the first data byte goes to the addressed register and each later byte goes to the next index. After the last register the index returns to register 0.
- R5: Only the low log2(NUM_REGS) bits of the register byte select the register, so larger values wrap modulo NUM_REGS.
- R6: A STOP inside a data byte discards that byte. No register changes and no `wr_strobe` occurs.
- R7: The read sequence is 0x88, a register byte, a repeated START, then 0x89. The block acknowledges 0x89 and then returns the selected register MSB first.
- R8: During a read, each ACK from the master moves the pointer up by one, wrapping to 0, and the next byte is sent. A NACK followed by STOP ends the read with SDA released.
- R9: After a write, the pointer holds the last register written. A read that starts directly with 0x89 returns that register.
- R10: For WR_HOLD_CYCLES cycles after a STOP that ends a write, the block ignores the bus. It does not acknowledge an address byte and keeps SDA released.
- R11: `sda_oe` is only ever asserted while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_rd_addr | input | log2(NUM_REGS) | Sensor-side read index |
| reg_rd_data | output | 8 | Register at `reg_rd_addr` |
| wr_strobe | output | 1 | One-cycle pulse per committed byte |
| wr_addr | output | log2(NUM_REGS) | Register written with the strobe |
| wr_data | output | 8 | Byte written with the strobe |

## Verification
The bench goes after the places where the pointer arithmetic is easy to get wrong: burst writes and burst reads that cross the top of the array, register bytes wider than the index, and a direct read after a burst write. A design that wraps badly puts data into the wrong register or returns it from the wrong one. A design that advances the pointer even on the first byte shifts everything by one. It also cuts a data byte short with STOP, starts transfers during the reset window and the post-write window, and sends near-miss addresses. A design that commits early, ignores the windows, or compares too few address bits then shows a stray register change or an ACK where none may appear. Every register is swept once through a single-byte write and once through a single-byte read, with values computed from the index.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam logic [6:0] TGT_DEV_ID = 7'b1000100;
   localparam int         BYTE_W     = 8;

   typedef enum logic [3:0] {
      ST_HOLD,
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_REG,
      ST_REG_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RD_ACK,
      ST_IGNORE
   } tgt_state_e;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_evt_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int LINES  = 2,
   parameter bit FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LINES-1:0] raw,
   output logic [LINES-1:0] clean
);

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic s1, s2;

      always_ff @(posedge clk) begin
         if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
         end else begin
            s1 <= raw[g];
            s2 <= s1;
         end
      end

      if (FILTER) begin : g_glitch
         logic s3, f;
         always_ff @(posedge clk) begin
            if (rst) begin
               s3 <= 1'b1;
               f  <= 1'b1;
            end else begin
               s3 <= s2;
               if (s2 == s3) f <= s2;
            end
         end
         assign clean[g] = f;
      end else begin : g_plain
         logic f;
         always_ff @(posedge clk) begin
            if (rst) f <= 1'b1;
            else     f <= s2;
         end
         assign clean[g] = f;
      end
   end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
   import i2c_tgt_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     scl,
   input  logic     sda,
   output bus_evt_t evt
);

   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_comb begin
      evt.scl_rise = scl & ~scl_q;
      evt.scl_fall = ~scl & scl_q;
      evt.start    = scl & scl_q & sda_q & ~sda;
      evt.stop     = scl & scl_q & ~sda_q & sda;
   end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr_a,
   output logic [WIDTH-1:0] rdata_a,
   input  logic [AW-1:0]    raddr_b,
   output logic [WIDTH-1:0] rdata_b
);

   logic [WIDTH-1:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)                          mem[g] <= '0;
         else if (we && waddr == AW'(g))   mem[g] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
   import i2c_tgt_pkg::*;
#(
   parameter int NUM_REGS       = 16,
   parameter int PWRUP_CYCLES   = 256,
   parameter int WR_HOLD_CYCLES = 1024,
   parameter bit GLITCH_FILTER  = 1'b1,
   localparam int AW            = $clog2(NUM_REGS),
   localparam int HOLD_MAX      = (PWRUP_CYCLES > WR_HOLD_CYCLES) ? PWRUP_CYCLES : WR_HOLD_CYCLES,
   localparam int HW            = $clog2(HOLD_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic [AW-1:0]     reg_rd_addr,
   output logic [BYTE_W-1:0] reg_rd_data,
   output logic              wr_strobe,
   output logic [AW-1:0]     wr_addr,
   output logic [BYTE_W-1:0] wr_data
);

   if (NUM_REGS < 2 || NUM_REGS > 256 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("NUM_REGS must be a power of two from 2 to 256");
   end
   if (PWRUP_CYCLES < 1 || WR_HOLD_CYCLES < 1) begin : g_bad_hold
      $error("hold windows must be at least one cycle");
   end

   // line conditioning and bus events
   logic [1:0] lines_f;
   logic       scl_f, sda_f;
   bus_evt_t   evt;

   i2c_line_filter #(.LINES(2), .FILTER(GLITCH_FILTER)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw   ({scl_in, sda_in}),
      .clean (lines_f)
   );
   assign scl_f = lines_f[1];
   assign sda_f = lines_f[0];

   i2c_bus_events u_evt (
      .clk (clk),
      .rst (rst),
      .scl (scl_f),
      .sda (sda_f),
      .evt (evt)
   );

   // control state
   tgt_state_e        state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [AW-1:0]     ptr;
   logic              rd_mode;
   logic              first_wr;
   logic              wrote;
   logic              mst_ack;
   logic              oe_q;
   logic [HW-1:0]     hold_cnt;
   logic              stb_q;
   logic [AW-1:0]     stb_addr;
   logic [BYTE_W-1:0] stb_data;

   logic [AW-1:0]     ptr_next;
   logic [AW-1:0]     bus_raddr;
   logic [BYTE_W-1:0] bus_rdata;
   logic [AW-1:0]     commit_addr;
   logic              byte_done;
   logic              hold_active;

   assign ptr_next    = AW'(ptr + 1'b1);
   assign bus_raddr   = (state == ST_RD_ACK) ? ptr_next : ptr;
   assign commit_addr = first_wr ? ptr : ptr_next;
   assign byte_done   = evt.scl_fall && (bit_cnt == 4'd8);
   assign hold_active = (state == ST_HOLD);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_HOLD;
         hold_cnt <= HW'(PWRUP_CYCLES);
         bit_cnt  <= '0;
         shreg    <= '0;
         ptr      <= '0;
         rd_mode  <= 1'b0;
         first_wr <= 1'b0;
         wrote    <= 1'b0;
         mst_ack  <= 1'b0;
         oe_q     <= 1'b0;
         stb_q    <= 1'b0;
         stb_addr <= '0;
         stb_data <= '0;
      end else begin
         stb_q <= 1'b0;
         if (state == ST_HOLD) begin
            oe_q <= 1'b0;
            if (hold_cnt == '0) state <= ST_IDLE;
            else                hold_cnt <= hold_cnt - 1'b1;
         end else if (evt.stop) begin
            oe_q  <= 1'b0;
            wrote <= 1'b0;
            if (wrote) begin
               state    <= ST_HOLD;
               hold_cnt <= HW'(WR_HOLD_CYCLES);
            end else begin
               state <= ST_IDLE;
            end
         end else if (evt.start) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_REG, ST_WDATA: begin
                  if (evt.scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_f};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     if (state == ST_ADDR) begin
                        if (shreg[BYTE_W-1:1] == TGT_DEV_ID) begin
                           rd_mode <= shreg[0];
                           oe_q    <= 1'b1;
                           state   <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IGNORE;
                        end
                     end else begin
                        oe_q  <= 1'b1;
                        state <= (state == ST_REG) ? ST_REG_ACK : ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (evt.scl_fall) begin
                     bit_cnt <= '0;
                     if (rd_mode) begin
                        shreg <= bus_rdata;
                        oe_q  <= ~bus_rdata[BYTE_W-1];
                        state <= ST_RDATA;
                     end else begin
                        oe_q  <= 1'b0;
                        state <= ST_REG;
                     end
                  end
               end
               ST_REG_ACK: begin
                  if (evt.scl_fall) begin
                     oe_q     <= 1'b0;
                     bit_cnt  <= '0;
                     ptr      <= shreg[AW-1:0];
                     first_wr <= 1'b1;
                     state    <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (evt.scl_fall) begin
                     oe_q     <= 1'b0;
                     bit_cnt  <= '0;
                     ptr      <= commit_addr;
                     first_wr <= 1'b0;
                     wrote    <= 1'b1;
                     stb_q    <= 1'b1;
                     stb_addr <= commit_addr;
                     stb_data <= shreg;
                     state    <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (evt.scl_rise) begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     oe_q  <= 1'b0;
                     state <= ST_RD_ACK;
                  end else if (evt.scl_fall) begin
                     shreg <= {shreg[BYTE_W-2:0], 1'b0};
                     oe_q  <= ~shreg[BYTE_W-2];
                  end
               end
               ST_RD_ACK: begin
                  if (evt.scl_rise) begin
                     mst_ack <= ~sda_f;
                  end else if (evt.scl_fall) begin
                     if (mst_ack) begin
                        ptr     <= ptr_next;
                        shreg   <= bus_rdata;
                        oe_q    <= ~bus_rdata[BYTE_W-1];
                        bit_cnt <= '0;
                        state   <= ST_RDATA;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   i2c_reg_bank #(.DEPTH(NUM_REGS), .WIDTH(BYTE_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we      (stb_q),
      .waddr   (stb_addr),
      .wdata   (stb_data),
      .raddr_a (bus_raddr),
      .rdata_a (bus_rdata),
      .raddr_b (reg_rd_addr),
      .rdata_b (reg_rd_data)
   );

   assign sda_oe    = oe_q;
   assign wr_strobe = stb_q;
   assign wr_addr   = stb_addr;
   assign wr_data   = stb_data;

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
   input logic clk,
   input logic rst,
   input logic scl_lvl,
   input logic sda_oe,
   input logic wr_strobe,
   input logic stop_evt,
   input logic scl_fall_evt,
   input logic hold_active
);

   AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
      $rose(sda_oe) |-> !scl_lvl); // R11

   AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (rst)
      stop_evt |=> !sda_oe); // R8

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      wr_strobe |=> !wr_strobe); // R3

   AST_COMMIT_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
      wr_strobe |-> $past(scl_fall_evt)); // R6

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
      hold_active |-> (!sda_oe && !wr_strobe)); // R10

endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
   .clk          (clk),
   .rst          (rst),
   .scl_lvl      (scl_f),
   .sda_oe       (sda_oe),
   .wr_strobe    (wr_strobe),
   .stop_evt     (evt.stop),
   .scl_fall_evt (evt.scl_fall),
   .hold_active  (hold_active)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;

   localparam int NR    = 16;
   localparam int AW    = 4;
   localparam int Q     = 8;
   localparam int PWRUP = 64;
   localparam int WHOLD = 600;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic          sda_oe;
   logic [AW-1:0] reg_rd_addr = '0;
   logic [7:0]    reg_rd_data;
   logic          wr_strobe;
   logic [AW-1:0] wr_addr;
   logic [7:0]    wr_data;
   wire           sda_bus = sda_m & ~sda_oe;

   int checks = 0;
   int failures = 0;
   int stb_cnt = 0;
   int oe_rises = 0;
   int bad_rises = 0;
   logic [AW-1:0] last_addr = '0;
   logic [7:0]    last_data = '0;
   logic          oe_prev = 1'b0;
   logic [7:0]    exp_regs [NR];

   always #5 clk = ~clk;

   i2c_reg_target #(.NUM_REGS(NR), .PWRUP_CYCLES(PWRUP), .WR_HOLD_CYCLES(WHOLD)) u0 (
      .clk         (clk),
      .rst         (rst),
      .scl_in      (scl_m),
      .sda_in      (sda_bus),
      .sda_oe      (sda_oe),
      .reg_rd_addr (reg_rd_addr),
      .reg_rd_data (reg_rd_data),
      .wr_strobe   (wr_strobe),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (wr_strobe) begin
            stb_cnt++;
            last_addr = wr_addr;
            last_data = wr_data;
         end
         if (sda_oe && !oe_prev) begin
            oe_rises++;
            if (scl_m) bad_rises++;
         end
      end
      oe_prev = sda_oe;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      sda_m = 1'b0; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b1; wt(2*Q);
      sda_m = 1'b1; wt(2*Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b;    wt(Q);
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      b = sda_bus;  wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output int ack);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(a);
      ack = (a == 1'b0) ? 1 : 0;
   endtask

   task automatic recv_byte(input logic ack, output logic [7:0] d);
      logic bv;
      for (int i = 7; i >= 0; i--) begin
         get_bit(bv);
         d[i] = bv;
      end
      put_bit(~ack);
   endtask

   // burst write; returns number of acknowledged bytes
   task automatic wr_burst(input logic [7:0] ra, input int n, input logic [7:0] seed, output int acks);
      int a;
      acks = 0;
      i2c_start();
      send_byte(8'h88, a); acks += a;
      send_byte(ra, a);    acks += a;
      for (int k = 0; k < n; k++) begin
         send_byte(8'(seed + 8'(k * 29)), a);
         acks += a;
         exp_regs[AW'(ra[AW-1:0] + AW'(k))] = 8'(seed + 8'(k * 29));
      end
      i2c_stop();
   endtask

   task automatic sensor_rd(input int idx, output int val);
      reg_rd_addr = AW'(idx);
      wt(1);
      val = int'(reg_rd_data);
   endtask

   initial begin : watchdog
      wt(190000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int a, acks, v, s0;
      logic [7:0] d;
      for (int i = 0; i < NR; i++) exp_regs[i] = 8'h00;
      wt(4);
      rst = 1'b0;

      // R1: power-up window ignores an early START
      i2c_start();
      send_byte(8'h88, a);
      chk("R1 early start no ack", a, 0);
      i2c_stop();
      wt(PWRUP + 20);
      chk("R1 oe released", int'(sda_oe), 0);
      chk("R1 strobe low", int'(wr_strobe), 0);
      for (int i = 0; i < NR; i++) begin
         sensor_rd(i, v);
         chk("R1 reg reset", v, 0);
      end

      // R3: single-byte write sweep over all registers
      for (int i = 0; i < NR; i++) begin
         s0 = stb_cnt;
         wr_burst(8'(i), 1, 8'(i * 37 + 5), acks);
         chk("R3 write acks", acks, 3);
         chk("R3 strobe count", stb_cnt - s0, 1);
         chk("R3 wr_addr", int'(last_addr), i);
         chk("R3 wr_data", int'(last_data), (i * 37 + 5) & 255);
         sensor_rd(i, v);
         chk("R3 reg value", v, (i * 37 + 5) & 255);
         wt(WHOLD + 50);
      end

      // R7: single-byte read sweep
      for (int i = 0; i < NR; i++) begin
         i2c_start();
         send_byte(8'h88, a);
         send_byte(8'(i), a);
         i2c_start();
         send_byte(8'h89, a);
         chk("R7 read addr ack", a, 1);
         recv_byte(1'b0, d);
         i2c_stop();
         chk("R7 read data", int'(d), int'(exp_regs[i]));
      end

      // R4: burst write across the top of the array
      s0 = stb_cnt;
      wr_burst(8'd14, 4, 8'hA0, acks);
      chk("R4 burst acks", acks, 6);
      chk("R4 strobe count", stb_cnt - s0, 4);
      chk("R4 last wr_addr wraps", int'(last_addr), 1);
      wt(WHOLD + 50);
      for (int i = 0; i < NR; i++) begin
         sensor_rd(i, v);
         chk("R4 array after burst", v, int'(exp_regs[i]));
      end

      // R5: register byte above the count wraps
      wr_burst(8'h23, 1, 8'h5A, acks);
      wt(WHOLD + 50);
      sensor_rd(3, v);
      chk("R5 wrapped register", v, 8'h5A);

      // R6: STOP inside a data byte
      s0 = stb_cnt;
      i2c_start();
      send_byte(8'h88, a);
      send_byte(8'h05, a);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      i2c_stop();
      wt(20);
      sensor_rd(5, v);
      chk("R6 reg unchanged", v, int'(exp_regs[5]));
      chk("R6 no strobe", stb_cnt - s0, 0);

      // R8: burst read wraps, NACK + STOP releases SDA
      i2c_start();
      send_byte(8'h88, a);
      send_byte(8'd15, a);
      i2c_start();
      send_byte(8'h89, a);
      recv_byte(1'b1, d);
      chk("R8 byte 15", int'(d), int'(exp_regs[15]));
      recv_byte(1'b1, d);
      chk("R8 byte 0", int'(d), int'(exp_regs[0]));
      recv_byte(1'b0, d);
      chk("R8 byte 1", int'(d), int'(exp_regs[1]));
      i2c_stop();
      wt(10);
      chk("R8 oe released", int'(sda_oe), 0);

      // R9: direct read returns last written register
      wr_burst(8'd7, 2, 8'h3C, acks);
      wt(WHOLD + 50);
      i2c_start();
      send_byte(8'h89, a);
      chk("R9 direct read ack", a, 1);
      recv_byte(1'b0, d);
      i2c_stop();
      chk("R9 direct read data", int'(d), int'(exp_regs[8]));

      // R10: window after a write
      wr_burst(8'd2, 1, 8'h77, acks);
      s0 = oe_rises;
      i2c_start();
      send_byte(8'h88, a);
      chk("R10 no ack in window", a, 0);
      chk("R10 sda released in window", oe_rises - s0, 0);
      i2c_stop();
      wt(WHOLD + 50);
      i2c_start();
      send_byte(8'h88, a);
      chk("R10 ack after window", a, 1);
      i2c_stop();
      wt(20);

      // R2: near-miss addresses
      s0 = oe_rises;
      i2c_start();
      send_byte(8'h90, a);
      chk("R2 wrong addr nack", a, 0);
      send_byte(8'h02, a);
      send_byte(8'hFF, a);
      i2c_stop();
      i2c_start();
      send_byte(8'h44, a);
      chk("R2 shifted addr nack", a, 0);
      i2c_stop();
      i2c_start();
      send_byte(8'h8B, a);
      chk("R2 read near-miss nack", a, 0);
      i2c_stop();
      chk("R2 never drove sda", oe_rises - s0, 0);
      sensor_rd(2, v);
      chk("R2 reg unchanged", v, 8'h77);

      // R11: SDA only pulled while SCL low
      chk("R11 oe rise while scl high", bad_rises, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule